// File: doc/BRIEF.md
# Target Information-Transfer Phase Sequencer

This block is the target-side engine for the information-transfer part of a parallel peripheral bus. A start pulse carries a phase code, a byte count and a settle time. The engine drives the three phase lines (message, control/data, direction) for that phase. It holds them for the settle time and then moves the requested number of bytes, one fully interlocked request/acknowledge handshake per byte.

When the direction line is high, bytes go from target to initiator. They come from a host-side stream, and each byte is placed on the data lines before the request is raised. When the direction line is low, bytes go from initiator to target. Each byte is captured from the sampled data lines when the acknowledge is seen, and handed to the host with a one-cycle valid strobe. After the last byte the engine releases the phase lines and pulses done. The acknowledge and data inputs are assumed to be already synchronized to the clock.

Top module: `xfer_phase_seq`

## Requirements
- R1: The phase code is `phase_i = {msg, cd, io}`. Data-out is 000, data-in is 001, command is 010, status is 011, message-out is 110 and message-in is 111. While busy, `msg_o`, `cd_o` and `io_o` equal the accepted code, starting the cycle after the accepted start.
- R2: A start with a reserved code (100 or 101) has no effect. Busy, the phase lines, REQ and done all stay low.
- R3: With settle value S and a nonzero count, `req_o` first rises exactly S+1 clock cycles after the phase lines change.
- R4: `req_o` falls in the cycle after `ack_i` is sampled high and stays low while `ack_i` is high. It rises again one cycle after the cycle in which `ack_i` is first sampled low, and only if bytes remain.
- R5: In an initiator-to-target phase (io=0), `rx_valid_o` pulses for one cycle right after the edge where `ack_i` is sampled high. `rx_data_o` then holds the `data_i` value sampled at that edge. In a target-to-initiator phase (io=1), `rx_valid_o` stays low.
- R6: In a target-to-initiator phase, `data_oe_o` is high while busy. `data_o` carries the next host byte before REQ rises and holds it until ACK is seen. `tx_pop_o` pulses once per byte taken from `tx_data_i`. No bytes are taken in initiator-to-target phases, and `data_oe_o` is low then.
- R7: Exactly `count_i` handshakes are performed. `done_o` then pulses for one cycle, starting the cycle after the last ACK is seen low. In that same cycle the phase lines, busy and `data_oe_o` return low.
- R8: With a count of zero, no REQ is raised. `done_o` pulses S+1 cycles after the phase lines change.
- R9: A start while busy is ignored. The phase lines, the byte sequence and the count of the running phase are unchanged.
- R10: During reset, REQ, the phase lines, busy, done, `data_oe_o`, `rx_valid_o` and `tx_pop_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a phase |
| phase_i | input | 3 | Phase code {msg, cd, io} |
| count_i | input | CNT_W | Number of bytes in the phase |
| settle_i | input | SET_W | Settle cycles before the first REQ, minus one |
| tx_data_i | input | DATA_W | Next host byte for target-to-initiator phases |
| tx_pop_o | output | 1 | Host byte consumed; advance the stream |
| ack_i | input | 1 | Synchronized ACK from the initiator |
| data_i | input | DATA_W | Synchronized bus data from the initiator |
| req_o | output | 1 | REQ to the initiator |
| msg_o | output | 1 | Message phase line |
| cd_o | output | 1 | Control/data phase line |
| io_o | output | 1 | Direction phase line (1 = to initiator) |
| data_o | output | DATA_W | Bus data driven by the target |
| data_oe_o | output | 1 | Drive enable for the data lines |
| rx_data_o | output | DATA_W | Byte received from the initiator |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| busy_o | output | 1 | A phase is in progress |
| done_o | output | 1 | One-cycle end-of-phase pulse |

## Verification
Several properties are checked on every cycle. REQ never rises or stays up while ACK is high. A received strobe always follows an ACK that met a raised REQ. Driven data stays stable while a target-to-initiator REQ waits. No reserved code ever reaches the phase lines, the lines stay constant for the whole of a busy interval, and done is a single-cycle pulse with REQ low. Other behaviour can only be shown by the bench's scenarios: the exact settle distance to the first REQ, the byte values and their order in both directions, the exact number of handshakes, the zero-count case, and the rejection of reserved codes and of a start while busy.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT_LOW,
    ST_PREP
  } hs_state_e;

  typedef struct packed {
    logic msg;
    logic cd;
    logic io;
  } phase_lines_t;

  // msg without cd is not a defined phase
  function automatic logic phase_legal(input logic [2:0] code);
    return !(code[2] && !code[1]);
  endfunction

endpackage

// File: rtl/xfer_phase_decode.sv
module xfer_phase_decode
  import xfer_pkg::*;
(
  input  logic [2:0]   phase_i,
  output logic         legal_o,
  output phase_lines_t lines_o,
  output logic         dir_in_o
);
  always_comb begin
    legal_o     = phase_legal(phase_i);
    lines_o.msg = phase_i[2];
    lines_o.cd  = phase_i[1];
    lines_o.io  = phase_i[0];
    dir_in_o    = phase_i[0];
  end
endmodule

// File: rtl/xfer_settle_timer.sv
module xfer_settle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         zero_o
);
  logic [W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tmr_q <= '0;
    else if (load_i)                 tmr_q <= val_i;
    else if (run_i && tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  assign zero_o = (tmr_q == '0);
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         empty_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/xfer_phase_seq.sv
module xfer_phase_seq
  import xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SET_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        phase_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic              msg_o,
  output logic              cd_o,
  output logic              io_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              done_o
);

  hs_state_e    state_q;
  phase_lines_t lines_q, dec_lines;
  logic         dec_legal, dec_dir_in;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic         tx_pop_q, rx_valid_q, done_q;
  logic         tmr_zero, cnt_empty;
  logic         accept, cnt_dec;

  xfer_phase_decode u_dec (
    .phase_i  (phase_i),
    .legal_o  (dec_legal),
    .lines_o  (dec_lines),
    .dir_in_o (dec_dir_in)
  );

  assign accept  = (state_q == ST_IDLE) && start_i && dec_legal;
  assign cnt_dec = (state_q == ST_REQ) && ack_i;

  xfer_settle_timer #(.W(SET_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (settle_i),
    .run_i  (state_q == ST_SETTLE),
    .zero_o (tmr_zero)
  );

  xfer_byte_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .val_i   (count_i),
    .dec_i   (cnt_dec),
    .empty_o (cnt_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lines_q    <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      tx_pop_q   <= 1'b0;
      rx_valid_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      tx_pop_q   <= 1'b0;
      rx_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            lines_q <= dec_lines;
            state_q <= ST_SETTLE;
            if (dec_dir_in && count_i != '0) begin
              tx_q     <= tx_data_i;
              tx_pop_q <= 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            if (cnt_empty) begin
              state_q <= ST_IDLE;
              lines_q <= '0;
              done_q  <= 1'b1;
            end else if (!ack_i) begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (ack_i) begin
            if (!lines_q.io) begin
              rx_q       <= data_i;
              rx_valid_q <= 1'b1;
            end
            state_q <= ST_WAIT_LOW;
          end
        end
        ST_WAIT_LOW: begin
          if (!ack_i) begin
            if (cnt_empty) begin
              state_q <= ST_IDLE;
              lines_q <= '0;
              done_q  <= 1'b1;
            end else begin
              if (lines_q.io) begin
                tx_q     <= tx_data_i;
                tx_pop_q <= 1'b1;
              end
              state_q <= ST_PREP;
            end
          end
        end
        ST_PREP: begin
          // data settles on the bus one cycle ahead of REQ
          if (!ack_i) state_q <= ST_REQ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign req_o      = (state_q == ST_REQ);
  assign msg_o      = lines_q.msg;
  assign cd_o       = lines_q.cd;
  assign io_o       = lines_q.io;
  assign data_o     = tx_q;
  assign data_oe_o  = busy_o && lines_q.io;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_pop_o   = tx_pop_q;
  assign done_o     = done_q;

endmodule

// File: rtl/xfer_phase_seq_chk.sv
module xfer_phase_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              req_o,
  input logic              msg_o,
  input logic              cd_o,
  input logic              io_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              rx_valid_o,
  input logic              busy_o,
  input logic              done_o
);

  // R1
  legal_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_o && !cd_o));

  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);

  // R4
  req_hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && ack_i) |=> !req_o);

  // R5
  rx_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(req_o && ack_i && !io_o));

  // R6
  drive_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && io_o) |-> data_oe_o);

  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && io_o && !ack_i) |=> $stable(data_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!req_o && !busy_o));

  // R9
  lines_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable({msg_o, cd_o, io_o}));

endmodule

bind xfer_phase_seq xfer_phase_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .req_o      (req_o),
  .msg_o      (msg_o),
  .cd_o       (cd_o),
  .io_o       (io_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .rx_valid_o (rx_valid_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/xfer_phase_seq_test.sv
module xfer_phase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {phase[2:0], count[7:0], settle[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'b010, 8'd6, 8'd3},
    {3'b000, 8'd4, 8'd0},
    {3'b001, 8'd5, 8'd2},
    {3'b011, 8'd1, 8'd4},
    {3'b111, 8'd1, 8'd1},
    {3'b110, 8'd2, 8'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ack = 1'b0;
  logic [2:0] phase = '0;
  logic [7:0] count = '0, settle = '0, din = '0;
  logic [7:0] tx_data, dout, rx_data;
  logic tx_pop, req, msg, cd, io, oe, rx_valid, busy, done;
  int tx_idx = 0;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 90);
  endfunction

  assign tx_data = pat(tx_idx);
  always @(posedge clk) if (tx_pop) tx_idx <= tx_idx + 1;

  xfer_phase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .phase_i(phase),
    .count_i(count), .settle_i(settle), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .ack_i(ack), .data_i(din), .req_o(req), .msg_o(msg), .cd_o(cd), .io_o(io),
    .data_o(dout), .data_oe_o(oe), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic run_phase(input logic [2:0] ph, input int cnt, input int st, input bit poke);
    int base, k;
    logic [7:0] val;
    base = tx_idx;
    @(negedge clk);
    start = 1'b1; phase = ph; count = 8'(cnt); settle = 8'(st);
    @(negedge clk);
    start = 1'b0;
    chk({msg, cd, io} == ph, "R1", int'({msg, cd, io}), int'(ph));
    k = 0;
    while (!req && !done && k < 1000) begin @(negedge clk); k++; end
    if (cnt == 0) begin
      chk(done && !req, "R8", int'(req), 0);
      chk(k == st + 1, "R8", k, st + 1);
      return;
    end
    chk(k == st + 1, "R3", k, st + 1);
    for (int b = 0; b < cnt; b++) begin
      if (b > 0) begin
        k = 0;
        while (!req && k < 1000) begin @(negedge clk); k++; end
        chk(k == 1, "R4", k, 1);
      end
      val = 8'(200 + b * 11 + int'(ph));
      if (ph[0]) begin
        chk(oe == 1'b1, "R6", int'(oe), 1);
        chk(dout == pat(base + b), "R6", int'(dout), int'(pat(base + b)));
      end else begin
        chk(oe == 1'b0, "R6", int'(oe), 0);
        din = val;
      end
      if (poke && b == 0) begin
        start = 1'b1; phase = 3'b001; count = 8'd9;
        @(negedge clk);
        start = 1'b0;
        chk({msg, cd, io} == ph && req, "R9", int'({msg, cd, io}), int'(ph));
      end
      ack = 1'b1;
      @(negedge clk);
      chk(!req, "R4", int'(req), 0);
      if (!ph[0]) chk(rx_valid && rx_data == val, "R5", int'(rx_data), int'(val));
      else        chk(!rx_valid, "R5", int'(rx_valid), 0);
      repeat (2) begin
        @(negedge clk);
        chk(!req && !rx_valid, "R4", int'(req), 0);
      end
      ack = 1'b0;
      @(negedge clk);
      if (b == cnt - 1) begin
        chk(done, "R7", int'(done), 1);
        chk({msg, cd, io} == 3'b000 && !busy && !oe, "R7", int'({busy, msg, cd, io}), 0);
      end else begin
        chk(!done && !req, "R7", int'(done), 0);
      end
    end
    chk(tx_idx - base == (ph[0] ? cnt : 0), "R6", tx_idx - base, ph[0] ? cnt : 0);
    @(negedge clk);
    chk(!done, "R7", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(!req && !busy && !done && !oe && !rx_valid && !tx_pop && {msg, cd, io} == 3'b000,
        "R10", int'({req, busy, done, oe, msg, cd, io}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_phase(VEC[v][18:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);

    // R2: reserved codes
    for (int c = 4; c < 6; c++) begin
      @(negedge clk);
      start = 1'b1; phase = 3'(c); count = 8'd3; settle = 8'd0;
      @(negedge clk);
      start = 1'b0;
      repeat (5) begin
        chk(!busy && !req && !done && {msg, cd, io} == 3'b000, "R2",
            int'({busy, req, done, msg, cd, io}), 0);
        @(negedge clk);
      end
    end

    // R8: zero count, settle 2
    run_phase(3'b011, 0, 2, 1'b0);
    @(negedge clk);
    chk(!done && !busy, "R8", int'(done), 0);

    // R9: start while busy
    run_phase(3'b010, 3, 1, 1'b1);
    run_phase(3'b001, 2, 0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule